// File: doc/BRIEF.md
# Two-Client Mutual-Exclusion Arbiter

This block hands one shared resource to at most one of two clients, called left and right. Each client owns a request input and a grant output. The pair follows a return-to-zero handshake. A client raises its request and waits for its grant. It uses the resource while the grant is high, then drops the request. The arbiter answers by dropping the grant, and only after that can the resource pass to the other side.

Grants are registered, so every grant decision takes effect on the clock edge after the inputs that caused it. A grant follows its own request and moves only while the other grant is low. Mutual exclusion therefore holds in every cycle, whatever the clients do.

When both requests are pending and the resource is idle, a tie-break picks one client. The parameter `ALT_PRIO` selects the rule:

- `ALT_PRIO=0` gives the left client fixed precedence.
- `ALT_PRIO=1` alternates, so the client that was not granted most recently wins.

Top module: `mutex_arb2`

## Requirements
- R1: While `rst` is high at a clock edge, both grants are low after that edge. The alternation history is also set so that left wins the first tie.
- R2: `gnt_l` and `gnt_r` are never high in the same cycle.
- R3: `gnt_l` rises at an edge only if, just before that edge, `req_l` was high and `gnt_r` was low.
- R4: Once high, a grant stays high at every edge where its request is high. It falls at the first edge where its request is low.
- R5: The right side obeys the same raise and hold rules as the left side, with the roles of the two sides swapped.
- R6: With `ALT_PRIO=0`, if both requests are high and both grants are low, `gnt_l` rises at the next edge and `gnt_r` stays low.
- R7: With `ALT_PRIO=1`, a tie goes to the client other than the one granted most recently. The first tie after reset goes to left.
- R8: A client held off by the other grant keeps its request high. It is granted at the edge after the one where the other grant fell, so there is one idle cycle between the two grants.
- R9: A lone request with both grants low is granted at the next edge. A grant never rises while its own request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_l | input | 1 | Left client request |
| req_r | input | 1 | Right client request |
| gnt_l | output | 1 | Left client grant (registered) |
| gnt_r | output | 1 | Right client grant (registered) |

## Verification
The bound checker tests these properties on every cycle:
- Mutual exclusion of the grants.
- A grant may rise only on its own request while the other grant is low.
- A grant holds while its request is high and falls once the request drops.
- The fixed-priority tie outcome.
- The reset state.

The alternation history and the one-cycle gap before a waiting client is served depend on earlier cycles. The bench's reference model shows these on directed scenarios of ties, hand-overs and a long pseudo-random stream. It runs on a fixed-priority instance and an alternating instance side by side.

// File: rtl/mutex_arb2_pkg.sv
package mutex_arb2_pkg;

    localparam int unsigned N_CLIENTS = 2;
    localparam int unsigned IDX_L     = 0;
    localparam int unsigned IDX_R     = 1;

    typedef logic [N_CLIENTS-1:0] side_vec_t;

    typedef struct packed {
        side_vec_t gnt;     // bit IDX_L = left, bit IDX_R = right
        logic      last_r;  // 1: right was granted most recently
    } arb_state_t;

    localparam arb_state_t ARB_RESET = '{gnt: '0, last_r: 1'b1};

endpackage

// File: rtl/arb_tiebreak.sv
module arb_tiebreak
    import mutex_arb2_pkg::*;
#(
    parameter bit ALT_PRIO = 1'b0
) (
    input  side_vec_t req,
    input  logic      last_r,
    output side_vec_t pick
);

    side_vec_t tie_pick;

    generate
        if (ALT_PRIO) begin : g_alt
            always_comb begin
                tie_pick        = '0;
                tie_pick[IDX_L] = last_r;
                tie_pick[IDX_R] = ~last_r;
            end
        end else begin : g_fixed
            always_comb begin
                tie_pick        = '0;
                tie_pick[IDX_L] = 1'b1;
            end
        end
    endgenerate

    always_comb begin
        if (&req) begin
            pick = tie_pick;
        end else begin
            pick = req;
        end
    end

endmodule

// File: rtl/arb_side.sv
module arb_side (
    input  logic req,
    input  logic own_q,
    input  logic other_q,
    input  logic picked,
    output logic own_d
);

    always_comb begin
        if (own_q) begin
            own_d = req;
        end else begin
            own_d = req & ~other_q & picked;
        end
    end

endmodule

// File: rtl/mutex_arb2.sv
module mutex_arb2
    import mutex_arb2_pkg::*;
#(
    parameter bit ALT_PRIO = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req_l,
    input  logic req_r,
    output logic gnt_l,
    output logic gnt_r
);

    arb_state_t st_d, st_q;
    side_vec_t  req_vec;
    side_vec_t  pick;
    side_vec_t  gnt_next;

    always_comb begin
        req_vec        = '0;
        req_vec[IDX_L] = req_l;
        req_vec[IDX_R] = req_r;
    end

    arb_tiebreak #(.ALT_PRIO(ALT_PRIO)) u_tie (
        .req    (req_vec),
        .last_r (st_q.last_r),
        .pick   (pick)
    );

    generate
        for (genvar i = 0; i < N_CLIENTS; i++) begin : g_side
            arb_side u_side (
                .req     (req_vec[i]),
                .own_q   (st_q.gnt[i]),
                .other_q (st_q.gnt[N_CLIENTS-1-i]),
                .picked  (pick[i]),
                .own_d   (gnt_next[i])
            );
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.gnt = gnt_next;
        if (gnt_next[IDX_L] && !st_q.gnt[IDX_L]) begin
            st_d.last_r = 1'b0;
        end else if (gnt_next[IDX_R] && !st_q.gnt[IDX_R]) begin
            st_d.last_r = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ARB_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_l = st_q.gnt[IDX_L];
    assign gnt_r = st_q.gnt[IDX_R];

endmodule

// File: rtl/mutex_arb2_chk.sv
module mutex_arb2_chk #(
    parameter bit ALT_PRIO = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic req_l,
    input logic req_r,
    input logic gnt_l,
    input logic gnt_r
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!gnt_l && !gnt_r));

    a_r2_mutex: assert property (@(posedge clk) disable iff (rst)
        !(gnt_l && gnt_r));

    a_r3_left_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(gnt_l) |-> ($past(req_l) && !$past(gnt_r)));

    a_r4_left_hold: assert property (@(posedge clk) disable iff (rst)
        (gnt_l && req_l) |=> gnt_l);

    a_r4_left_fall: assert property (@(posedge clk) disable iff (rst)
        (gnt_l && !req_l) |=> !gnt_l);

    a_r5_right_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(gnt_r) |-> ($past(req_r) && !$past(gnt_l)));

    a_r5_right_hold: assert property (@(posedge clk) disable iff (rst)
        (gnt_r && req_r) |=> gnt_r);

    a_r5_right_fall: assert property (@(posedge clk) disable iff (rst)
        (gnt_r && !req_r) |=> !gnt_r);

    a_r6_fixed_tie: assert property (@(posedge clk) disable iff (rst)
        (!ALT_PRIO && req_l && req_r && !gnt_l && !gnt_r) |=> (gnt_l && !gnt_r));

    a_r9_lone_left: assert property (@(posedge clk) disable iff (rst)
        (req_l && !req_r && !gnt_l && !gnt_r) |=> gnt_l);

    a_r9_lone_right: assert property (@(posedge clk) disable iff (rst)
        (req_r && !req_l && !gnt_l && !gnt_r) |=> gnt_r);

endmodule

bind mutex_arb2 mutex_arb2_chk #(.ALT_PRIO(ALT_PRIO)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .req_l (req_l),
    .req_r (req_r),
    .gnt_l (gnt_l),
    .gnt_r (gnt_r)
);

// File: tb/mutex_arb2_tb.sv
`timescale 1ns/1ps
module mutex_arb2_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_l = 1'b0;
    logic req_r = 1'b0;
    logic fl, fr, al, ar;

    int errors = 0;
    int checks = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    mutex_arb2 #(.ALT_PRIO(1'b0)) u_dut (
        .clk(clk), .rst(rst), .req_l(req_l), .req_r(req_r), .gnt_l(fl), .gnt_r(fr)
    );
    mutex_arb2 #(.ALT_PRIO(1'b1)) u_alt (
        .clk(clk), .rst(rst), .req_l(req_l), .req_r(req_r), .gnt_l(al), .gnt_r(ar)
    );

    // Reference: owner 0 = none, 1 = left, 2 = right.
    int own_f = 0, own_a = 0;
    int prev_a = 2;

    always @(posedge clk) begin
        if (rst) begin
            own_f  <= 0;
            own_a  <= 0;
            prev_a <= 2;
        end else begin
            // fixed priority
            if (own_f == 1) own_f <= req_l ? 1 : 0;
            else if (own_f == 2) own_f <= req_r ? 2 : 0;
            else if (req_l) own_f <= 1;
            else if (req_r) own_f <= 2;
            // alternating
            if (own_a == 1) own_a <= req_l ? 1 : 0;
            else if (own_a == 2) own_a <= req_r ? 2 : 0;
            else if (req_l && req_r) begin
                own_a  <= (prev_a == 2) ? 1 : 2;
                prev_a <= (prev_a == 2) ? 1 : 2;
            end else if (req_l) begin
                own_a <= 1; prev_a <= 1;
            end else if (req_r) begin
                own_a <= 2; prev_a <= 2;
            end
        end
    end

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check("fixed owner", fl ? (fr ? 3 : 1) : (fr ? 2 : 0), own_f);
            check("alt owner",   al ? (ar ? 3 : 1) : (ar ? 2 : 0), own_a);
            check("R2 mutex", (fl && fr) || (al && ar), 0);
        end
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        tag = "R1";
        step(3);
        check("R1 reset grants", {fl, fr, al, ar}, 0);
        rst = 1'b0;
        step(1);
        check("R1 after release", {fl, fr, al, ar}, 0);

        tag = "R9";
        req_r = 1'b0; req_l = 1'b0; step(2);
        check("R9 no grant while idle", {fl, fr}, 0);
        req_l = 1'b1; step(1);
        check("R9 lone left next edge", fl, 1);

        tag = "R3";
        step(4);
        check("R4 left held", fl, 1);
        tag = "R4";
        req_l = 1'b0; step(1);
        check("R4 left released", fl, 0);

        tag = "R5";
        req_r = 1'b1; step(1);
        check("R5 lone right", fr, 1);
        step(3);
        req_r = 1'b0; step(1);
        check("R5 right released", fr, 0);

        tag = "R8";
        req_l = 1'b1; step(1);
        req_r = 1'b1; step(3);
        check("R8 right blocked", fr, 0);
        req_l = 1'b0; step(1);
        check("R8 idle gap", {fl, fr}, 0);
        step(1);
        check("R8 right served", fr, 1);
        req_r = 1'b0; step(2);

        tag = "R6";
        for (int t = 0; t < 4; t++) begin
            req_l = 1'b1; req_r = 1'b1; step(1);
            check("R6 fixed tie left", {fl, fr}, 2'b10);
            check("R7 alt tie", {al, ar}, (t % 2 == 0) ? 2'b10 : 2'b01);
            req_l = 1'b0; req_r = 1'b0; step(2);
        end
        tag = "R7";
        req_r = 1'b1; step(2); req_r = 1'b0; step(2);
        req_l = 1'b1; req_r = 1'b1; step(1);
        check("R7 alt tie after right", {al, ar}, 2'b10);
        req_l = 1'b0; req_r = 1'b0; step(2);

        tag = "R2";
        lfsr = 8'hA5;
        for (int c = 0; c < 400; c++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            req_l = lfsr[0] | lfsr[3];
            req_r = lfsr[1] | lfsr[6];
            step(1);
        end
        req_l = 1'b0; req_r = 1'b0; step(3);

        tag = "R1";
        rst = 1'b1; step(2);
        check("R1 reset again", {fl, fr, al, ar}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule